// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel data buses, called A and B, and can carry a word in either direction. Each direction owns a holding register with its own capture clock: the A-to-B register samples the A bus, and the B-to-A register samples the B bus. A per-direction source select chooses what the receiving bus gets. It can take the live word from the far bus, which passes straight through, or the word held in that direction's register.

An active-low output enable and a direction input decide which bus, if either, is driven. Each bus is modelled as a separate input, output and output-enable so that the block synthesizes without tristate pins. The output enables are pure combinational decodes of the enable and direction inputs. Capture into either register ignores the enable and direction state entirely. The block can therefore pass data in real time, store data, send stored data, or stay isolated while both registers load.

Top module: `dual_bus_xcvr`

## Requirements
- R1: On each rising edge of `clk_a2b` with `rst` low, the A-to-B register takes the value of `a_in`. The B-to-A register is not changed by that edge.
- R2: On each rising edge of `clk_b2a` with `rst` low, the B-to-A register takes the value of `b_in`. The A-to-B register is not changed by that edge.
- R3: A rising edge of a capture clock while `rst` is high clears that direction's register to zero. The other register is left alone.
- R4: While `oe_n` is 1, both `a_oe` and `b_oe` are 0 (isolation).
- R5: While `oe_n` is 0, `dir` = 1 gives `b_oe` = 1 and `a_oe` = 0, and `dir` = 0 gives `a_oe` = 1 and `b_oe` = 0. There is no clock latency.
- R6: With `sel_a2b` = 0, `b_out` equals the current `a_in` with no clock in between. With `sel_a2b` = 1, `b_out` equals the A-to-B register.
- R7: With `sel_b2a` = 0, `a_out` equals the current `b_in`. With `sel_b2a` = 1, `a_out` equals the B-to-A register.
- R8: Capture works in every enable and direction state. This includes isolation with both registers loading on the same edge, and capture from a bus whose own outputs are disabled.
- R9: `a_oe` and `b_oe` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a2b | input | 1 | Capture clock of the A-to-B register |
| clk_b2a | input | 1 | Capture clock of the B-to-A register |
| rst | input | 1 | Synchronous active-high reset, sampled by each capture clock |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| sel_a2b | input | 1 | B source: 0 live A, 1 stored A-to-B word |
| sel_b2a | input | 1 | A source: 0 live B, 1 stored B-to-A word |
| a_in | input | W | Word present on bus A |
| a_out | output | W | Word offered to bus A |
| a_oe | output | 1 | Bus A output enable |
| b_in | input | W | Word present on bus B |
| b_out | output | W | Word offered to bus B |
| b_oe | output | 1 | Bus B output enable |

## Verification
The hardest state to reach is one where both registers load on the same instant while neither bus is driven. Each register must then be shown to hold its own word, even though no port exposes a register directly. The bench pulses the two capture clocks together with `oe_n` high. It then sets both source selects to stored and reads each register back through the other bus's output. Before that read-back it changes the live inputs, so that a pass-through could not produce the expected words.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    typedef struct packed {
        logic drive_a;
        logic drive_b;
    } drive_t;

    localparam int unsigned NUM_PATHS = 2;
    localparam int unsigned PATH_A2B  = 0;
    localparam int unsigned PATH_B2A  = 1;

    function automatic drive_t decode_drive(input logic en_n, input logic to_b);
        drive_t d;
        d.drive_b = !en_n &&  to_b;
        d.drive_a = !en_n && !to_b;
        return d;
    endfunction

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/xcvr_src_mux.sv
module xcvr_src_mux
    import xcvr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  src_sel_e     sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (sel)
            SRC_STORED: y = stored;
            default:    y = live;
        endcase
    end
endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
    import xcvr_pkg::*;
(
    input  logic   oe_n,
    input  logic   dir,
    output drive_t drv
);
    always_comb drv = decode_drive(oe_n, dir);
endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk_a2b,
    input  logic         clk_b2a,
    input  logic         rst,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_a2b,
    input  logic         sel_b2a,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    // index PATH_A2B: source bus A, destination bus B; PATH_B2A the reverse
    logic [NUM_PATHS-1:0]        path_clk;
    src_sel_e [NUM_PATHS-1:0]    path_sel;
    logic [NUM_PATHS-1:0][W-1:0] path_src;
    logic [NUM_PATHS-1:0][W-1:0] path_held;
    logic [NUM_PATHS-1:0][W-1:0] path_dst;
    drive_t                      drv;

    assign path_clk[PATH_A2B] = clk_a2b;
    assign path_clk[PATH_B2A] = clk_b2a;
    assign path_sel[PATH_A2B] = src_sel_e'(sel_a2b);
    assign path_sel[PATH_B2A] = src_sel_e'(sel_b2a);
    assign path_src[PATH_A2B] = a_in;
    assign path_src[PATH_B2A] = b_in;

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        xcvr_capture_reg #(.W(W)) hold_i (
            .clk (path_clk[p]),
            .rst (rst),
            .d   (path_src[p]),
            .q   (path_held[p])
        );
        xcvr_src_mux #(.W(W)) mux_i (
            .sel    (path_sel[p]),
            .live   (path_src[p]),
            .stored (path_held[p]),
            .y      (path_dst[p])
        );
    end

    xcvr_drive_ctl ctl_i (
        .oe_n (oe_n),
        .dir  (dir),
        .drv  (drv)
    );

    assign b_out = path_dst[PATH_A2B];
    assign a_out = path_dst[PATH_B2A];
    assign a_oe  = drv.drive_a;
    assign b_oe  = drv.drive_b;
endmodule

// File: rtl/dual_bus_xcvr_chk.sv
module dual_bus_xcvr_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk_a2b,
    input logic         clk_b2a,
    input logic         rst,
    input logic         oe_n,
    input logic         dir,
    input logic         sel_a2b,
    input logic         sel_b2a,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_oe
);
    // set once the previous edge of that clock was a normal capture
    logic live_ab = 1'b0;
    logic live_ba = 1'b0;
    always_ff @(posedge clk_a2b) live_ab <= !rst;
    always_ff @(posedge clk_b2a) live_ba <= !rst;

    always_comb begin
        a_r9_one_driver: assert (!(a_oe && b_oe));
        a_r4_isolated:   assert (!oe_n || (!a_oe && !b_oe));
        a_r5_one_active: assert (oe_n || (a_oe != b_oe));
        a_r6_live_ab:    assert (sel_a2b || (b_out == a_in));
        a_r7_live_ba:    assert (sel_b2a || (a_out == b_in));
    end

    a_r1_capture_ab: assert property (@(posedge clk_a2b) disable iff (rst)
        (live_ab && sel_a2b) |-> (b_out == $past(a_in)));

    a_r2_capture_ba: assert property (@(posedge clk_b2a) disable iff (rst)
        (live_ba && sel_b2a) |-> (a_out == $past(b_in)));

    a_r3_clear_ab: assert property (@(posedge clk_a2b)
        rst |=> (rst || !sel_a2b || (b_out == '0)));
endmodule

bind dual_bus_xcvr dual_bus_xcvr_chk #(.W(W)) chk_i (
    .clk_a2b (clk_a2b),
    .clk_b2a (clk_b2a),
    .rst     (rst),
    .oe_n    (oe_n),
    .dir     (dir),
    .sel_a2b (sel_a2b),
    .sel_b2a (sel_b2a),
    .a_in    (a_in),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b_in    (b_in),
    .b_out   (b_out),
    .b_oe    (b_oe)
);

// File: tb/dual_bus_xcvr_tb_top.sv
module dual_bus_xcvr_tb_top;
    localparam int  W          = 8;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WDOG_LIMIT = 5000;

    logic         clk_a2b = 1'b0;
    logic         clk_b2a = 1'b0;
    logic         rst     = 1'b1;
    logic         oe_n    = 1'b1;
    logic         dir     = 1'b0;
    logic         sel_a2b = 1'b0;
    logic         sel_b2a = 1'b0;
    logic [W-1:0] a_in    = '0;
    logic [W-1:0] b_in    = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    dual_bus_xcvr #(.W(W)) dut_i (
        .clk_a2b (clk_a2b), .clk_b2a (clk_b2a), .rst (rst),
        .oe_n (oe_n), .dir (dir), .sel_a2b (sel_a2b), .sel_b2a (sel_b2a),
        .a_in (a_in), .a_out (a_out), .a_oe (a_oe),
        .b_in (b_in), .b_out (b_out), .b_oe (b_oe)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_ab();
        #(CLK_PERIOD/2) clk_a2b = 1'b1;
        #(CLK_PERIOD/2) clk_a2b = 1'b0;
    endtask

    task automatic pulse_ba();
        #(CLK_PERIOD/2) clk_b2a = 1'b1;
        #(CLK_PERIOD/2) clk_b2a = 1'b0;
    endtask

    task automatic pulse_both();
        #(CLK_PERIOD/2) begin clk_a2b = 1'b1; clk_b2a = 1'b1; end
        #(CLK_PERIOD/2) begin clk_a2b = 1'b0; clk_b2a = 1'b0; end
    endtask

    task automatic t_reset();
        rst = 1'b1; a_in = 8'hFF; b_in = 8'hFF;
        pulse_both();
        rst = 1'b0; sel_a2b = 1'b1; sel_b2a = 1'b1; oe_n = 1'b1;
        #1;
        check("R3 a2b cleared", b_out, '0);
        check("R3 b2a cleared", a_out, '0);
        check("R4 a_oe isolated", W'(a_oe), '0);
        check("R4 b_oe isolated", W'(b_oe), '0);
    endtask

    task automatic t_enables();
        for (int k = 0; k < 4; k++) begin
            oe_n = k[1]; dir = k[0];
            #1;
            check("R9 enables exclusive", W'(a_oe && b_oe), '0);
            check("R5 b_oe decode", W'(b_oe), W'(!k[1] && k[0]));
            check("R5 a_oe decode", W'(a_oe), W'(!k[1] && !k[0]));
        end
    endtask

    task automatic t_realtime();
        oe_n = 1'b0; dir = 1'b1; sel_a2b = 1'b0; a_in = 8'h5A;
        #1;
        check("R5 B driven", W'(b_oe), 1);
        check("R6 live A to B", b_out, 8'h5A);
        a_in = 8'hC3;
        #1;
        check("R6 live follows without clock", b_out, 8'hC3);
        dir = 1'b0; sel_b2a = 1'b0; b_in = 8'h96;
        #1;
        check("R5 A driven", W'(a_oe), 1);
        check("R7 live B to A", a_out, 8'h96);
    endtask

    task automatic t_store_ab();
        // A is not driven here (dir=1), its input path still captures: R8
        oe_n = 1'b0; dir = 1'b1; sel_a2b = 1'b0; sel_b2a = 1'b1; a_in = 8'h3C;
        pulse_ab();
        a_in = 8'h11; sel_a2b = 1'b1;
        #1;
        check("R1 stored A to B", b_out, 8'h3C);
        check("R8 capture from undriven bus", b_out, 8'h3C);
        check("R1 b2a untouched", a_out, '0);
    endtask

    task automatic t_store_ba();
        b_in = 8'hE7;
        pulse_ba();
        b_in = 8'h00; dir = 1'b0; sel_b2a = 1'b1;
        #1;
        check("R2 stored B to A", a_out, 8'hE7);
        check("R7 stored select", a_out, 8'hE7);
        check("R2 a2b untouched", b_out, 8'h3C);
    endtask

    task automatic t_isolation();
        oe_n = 1'b1; sel_a2b = 1'b0; sel_b2a = 1'b0; a_in = 8'hA5; b_in = 8'h5A;
        pulse_both();
        a_in = 8'h01; b_in = 8'h02;
        #1;
        check("R4 a_oe off", W'(a_oe), '0);
        check("R4 b_oe off", W'(b_oe), '0);
        sel_a2b = 1'b1; sel_b2a = 1'b1;
        #1;
        check("R8 isolated a2b load", b_out, 8'hA5);
        check("R8 isolated b2a load", a_out, 8'h5A);
    endtask

    task automatic t_partial_reset();
        rst = 1'b1;
        pulse_ab();
        rst = 1'b0;
        #1;
        check("R3 a2b cleared alone", b_out, '0);
        check("R3 b2a kept", a_out, 8'h5A);
    endtask

    initial begin
        t_reset();
        t_enables();
        t_realtime();
        t_store_ab();
        t_store_ba();
        t_isolation();
        t_partial_reset();
        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < WDOG_LIMIT && !done; n++) #(CLK_PERIOD);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule